// File: doc/BRIEF.md
# TDM Network-Mode Slot Receiver

This block is the receive half of a serial audio port that shares one data line with other devices. The bus carries time-division-multiplexed frames. A master device drives the bit clock and the frame sync, and both reach this block as inputs. The block brings those inputs into its own system clock domain and samples the data line on every falling bit-clock edge. It finds the start of each frame from the rising edge of the frame sync, and it counts bits and slots through the frame.

A frame holds one to four slots, and all slots in a frame have one width of 8 or 16 bits. Each slot is either assigned to this device or reserved for others. The block keeps the words from assigned slots only. Each kept word goes to one of two places, chosen by a per-slot routing bit: a shared eight-word receive FIFO with a ready/valid read port, or that slot's own holding register with a valid flag. The FIFO fill level drives a level interrupt against a programmable warning limit. Overruns of the FIFO and of the holding registers are recorded in sticky flags.

The receiver is one state machine with three states:
- `ST_HUNT` waits for the first frame after reset.
- `ST_SLOT` assembles the bits of the slots in use.
- `ST_GAP` ignores bits after the last slot in use, until the next frame sync.

Its transitions are:
- frame-start moves from any state to `ST_SLOT`, at slot 0, bit 0.
- last-slot-done moves from `ST_SLOT` to `ST_GAP`.
- slot-advance keeps `ST_SLOT` and steps to the next slot.

Top module: `tdm_slot_rx`

## Requirements
- R1: After reset the block shows the following: `fifo_count` is 0, `rd_valid` is 0, `irq` is 0, `slot_valid` is 0000, `slot_ovr` is 0000 and `fifo_ovr` is 0.
- R2: A frame starts at a bit sampled on a falling `bclk` edge when `fsync` is 1 there and was 0 at the previous sample. That bit is bit 0 of slot 0. Both a one-bit sync and a sync that stays high for the whole first slot are accepted. The slot index steps every slot width. `cfg_nslots` holds the slot count minus one. Bits after the last slot in use are discarded until the next frame start.
- R3: In 16-bit mode (`cfg_word16`=1), each slot's first bit is the MSB of its 16-bit word.
- R4: In 8-bit mode (`cfg_word16`=0), each slot carries 8 bits, MSB first. The word is zero-extended to 16 bits.
- R5: A word from slot k with `cfg_rx_mask[k]`=0 is discarded. It reaches neither the FIFO nor any slot register.
- R6: A word from an assigned slot k with `cfg_route_reg[k]`=0 is written to the FIFO. FIFO words are read out in arrival order: the word at the head is on `rd_data` while `rd_valid`=1, and it is removed on a clock edge where `rd_ready`=1.
- R7: A word from an assigned slot k with `cfg_route_reg[k]`=1 is written to `slot_data[16k+15:16k]` and sets `slot_valid[k]`. A one-cycle pulse on `slot_rd[k]` clears `slot_valid[k]`.
- R8: A new word for slot k that arrives while `slot_valid[k]` is still 1 sets the sticky flag `slot_ovr[k]`. The new word replaces the old one.
- R9: The FIFO holds 8 words. A word that arrives while it is full is dropped and sets the sticky flag `fifo_ovr`. The 8 stored words are kept.
- R10: `irq` is 1 exactly while `fifo_count` is strictly greater than `cfg_warn_lim`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Bit clock from the bus master |
| fsync | input | 1 | Frame sync from the bus master |
| sdata | input | 1 | Shared serial data line |
| cfg_word16 | input | 1 | 1: 16-bit slots, 0: 8-bit slots |
| cfg_nslots | input | 2 | Slots per frame minus one |
| cfg_rx_mask | input | 4 | Slot k is assigned to this device when bit k is 1 |
| cfg_route_reg | input | 4 | 1: slot k goes to its holding register, 0: slot k goes to the FIFO |
| cfg_warn_lim | input | 4 | FIFO warning limit |
| rd_valid | output | 1 | FIFO head word available |
| rd_ready | input | 1 | Consumer takes the head word |
| rd_data | output | 16 | FIFO head word |
| fifo_count | output | 4 | Words held in the FIFO |
| fifo_ovr | output | 1 | Sticky FIFO overrun |
| irq | output | 1 | FIFO level interrupt |
| slot_data | output | 64 | Per-slot holding registers, slot k in bits 16k+15:16k |
| slot_valid | output | 4 | Per-slot unread flags |
| slot_rd | input | 4 | Per-slot read strobes, clear the valid flag |
| slot_ovr | output | 4 | Sticky per-slot overrun flags |

## Verification
The hardest state to reach from the ports is a full FIFO that still receives words. It needs more than eight assigned FIFO-routed slots to arrive with no read in between, so it spans several frames. The stimulus holds `rd_ready` low across three four-slot frames, which is twelve words, and then drains the FIFO. The drain must return the first eight words in order, and `fifo_ovr` must be set. The holding-register overrun is reached in a similar way: a second frame is sent while only one slot register has been read.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_SLOT = 2'd1,
        ST_GAP  = 2'd2
    } rx_state_e;
endpackage

// File: rtl/tdm_rx_sync.sv
module tdm_rx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fsync,
    input  logic sdata,
    output logic bit_stb,
    output logic fs_bit,
    output logic sd_bit
);
    logic [2:0] bclk_q;
    logic [1:0] fs_q;
    logic [1:0] sd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q <= '0;
            fs_q   <= '0;
            sd_q   <= '0;
        end else begin
            bclk_q <= {bclk_q[1:0], bclk};
            fs_q   <= {fs_q[0], fsync};
            sd_q   <= {sd_q[0], sdata};
        end
    end

    // falling edge of the bit clock, aligned with the second stage of data and sync
    assign bit_stb = bclk_q[2] & ~bclk_q[1];
    assign fs_bit  = fs_q[1];
    assign sd_bit  = sd_q[1];
endmodule

// File: rtl/tdm_rx_framer.sv
module tdm_rx_framer
    import tdm_rx_pkg::*;
#(
    parameter int WMAX  = 16,
    parameter int SLOTS = 4,
    localparam int SW = $clog2(SLOTS),
    localparam int BW = $clog2(WMAX)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_stb,
    input  logic            fs_bit,
    input  logic            sd_bit,
    input  logic            cfg_word16,
    input  logic [SW-1:0]   cfg_nslots,
    output logic            commit,
    output logic [SW-1:0]   commit_slot,
    output logic [WMAX-1:0] commit_word
);
    rx_state_e       state, state_nxt;
    logic [SW-1:0]   slot_q, cur_slot;
    logic [BW-1:0]   bit_q, cur_bit;
    logic [WMAX-1:0] shreg, sh_nxt;
    logic            fs_prev;
    logic            fs_start, active, last_bit, last_slot;

    assign fs_start  = bit_stb & fs_bit & ~fs_prev;
    assign active    = bit_stb & (fs_start | (state == ST_SLOT));
    assign cur_bit   = fs_start ? '0 : bit_q;
    assign cur_slot  = fs_start ? '0 : slot_q;
    assign last_bit  = cur_bit == (cfg_word16 ? BW'(WMAX - 1) : BW'(WMAX / 2 - 1));
    assign last_slot = cur_slot == cfg_nslots;
    assign sh_nxt    = {shreg[WMAX-2:0], sd_bit};

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HUNT: if (fs_start) state_nxt = ST_SLOT;
            ST_SLOT: begin
                if (fs_start)                           state_nxt = ST_SLOT;
                else if (active && last_bit && last_slot) state_nxt = ST_GAP;
            end
            ST_GAP:  if (fs_start) state_nxt = ST_SLOT;
            default: state_nxt = ST_HUNT;
        endcase
    end

    // state register and slot / bit counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_HUNT;
            slot_q  <= '0;
            bit_q   <= '0;
            shreg   <= '0;
            fs_prev <= 1'b0;
        end else begin
            state <= state_nxt;
            if (bit_stb) fs_prev <= fs_bit;
            if (active) begin
                shreg  <= sh_nxt;
                bit_q  <= last_bit ? '0 : cur_bit + 1'b1;
                slot_q <= last_bit ? cur_slot + 1'b1 : cur_slot;
            end
        end
    end

    // outputs
    always_comb begin
        commit      = active & last_bit;
        commit_slot = cur_slot;
        commit_word = cfg_word16 ? sh_nxt : {{(WMAX/2){1'b0}}, sh_nxt[WMAX/2-1:0]};
    end
endmodule

// File: rtl/tdm_rx_fifo.sv
module tdm_rx_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_ready,
    output logic             pop_valid,
    output logic [WIDTH-1:0] pop_data,
    output logic [CW-1:0]    count,
    output logic             ovr
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic             full, do_push, do_pop;

    assign full      = count == CW'(DEPTH);
    assign do_push   = push & ~full;
    assign pop_valid = count != '0;
    assign do_pop    = pop_ready & pop_valid;
    assign pop_data  = mem[rptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovr   <= 1'b0;
        end else begin
            if (do_push) begin
                mem[wptr] <= push_data;
                wptr      <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            end
            if (do_pop) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            if (push && full) ovr <= 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/tdm_rx_slotregs.sv
module tdm_rx_slotregs #(
    parameter int SLOTS = 4,
    parameter int WIDTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SLOTS-1:0]       wr,
    input  logic [WIDTH-1:0]       word,
    input  logic [SLOTS-1:0]       rd,
    output logic [SLOTS*WIDTH-1:0] data,
    output logic [SLOTS-1:0]       valid,
    output logic [SLOTS-1:0]       ovr
);
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data[k*WIDTH +: WIDTH] <= '0;
                valid[k]               <= 1'b0;
                ovr[k]                 <= 1'b0;
            end else if (wr[k]) begin
                data[k*WIDTH +: WIDTH] <= word;
                valid[k]               <= 1'b1;
                if (valid[k] && !rd[k]) ovr[k] <= 1'b1;
            end else if (rd[k]) begin
                valid[k] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx #(
    parameter int SLOTS = 4,
    parameter int WMAX  = 16,
    parameter int DEPTH = 8,
    localparam int SW = $clog2(SLOTS),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bclk,
    input  logic                  fsync,
    input  logic                  sdata,
    input  logic                  cfg_word16,
    input  logic [SW-1:0]         cfg_nslots,
    input  logic [SLOTS-1:0]      cfg_rx_mask,
    input  logic [SLOTS-1:0]      cfg_route_reg,
    input  logic [CW-1:0]         cfg_warn_lim,
    output logic                  rd_valid,
    input  logic                  rd_ready,
    output logic [WMAX-1:0]       rd_data,
    output logic [CW-1:0]         fifo_count,
    output logic                  fifo_ovr,
    output logic                  irq,
    output logic [SLOTS*WMAX-1:0] slot_data,
    output logic [SLOTS-1:0]      slot_valid,
    input  logic [SLOTS-1:0]      slot_rd,
    output logic [SLOTS-1:0]      slot_ovr
);
    logic            bit_stb, fs_bit, sd_bit;
    logic            commit, hit, fifo_push;
    logic [SW-1:0]   commit_slot;
    logic [WMAX-1:0] commit_word;
    logic [SLOTS-1:0] reg_wr;

    tdm_rx_sync u_sync (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .sdata(sdata),
        .bit_stb(bit_stb), .fs_bit(fs_bit), .sd_bit(sd_bit)
    );

    tdm_rx_framer #(.WMAX(WMAX), .SLOTS(SLOTS)) u_framer (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .fs_bit(fs_bit), .sd_bit(sd_bit),
        .cfg_word16(cfg_word16), .cfg_nslots(cfg_nslots),
        .commit(commit), .commit_slot(commit_slot), .commit_word(commit_word)
    );

    assign hit       = commit & cfg_rx_mask[commit_slot];
    assign fifo_push = hit & ~cfg_route_reg[commit_slot];
    always_comb begin
        reg_wr = '0;
        reg_wr[commit_slot] = hit & cfg_route_reg[commit_slot];
    end

    tdm_rx_fifo #(.DEPTH(DEPTH), .WIDTH(WMAX)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(fifo_push), .push_data(commit_word),
        .pop_ready(rd_ready), .pop_valid(rd_valid), .pop_data(rd_data),
        .count(fifo_count), .ovr(fifo_ovr)
    );

    tdm_rx_slotregs #(.SLOTS(SLOTS), .WIDTH(WMAX)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .word(commit_word), .rd(slot_rd),
        .data(slot_data), .valid(slot_valid), .ovr(slot_ovr)
    );

    assign irq = fifo_count > cfg_warn_lim;
endmodule

// File: rtl/tdm_slot_rx_chk.sv
module tdm_slot_rx_chk #(
    parameter int SLOTS = 4,
    parameter int WMAX  = 16,
    parameter int DEPTH = 8,
    localparam int SW = $clog2(SLOTS),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  commit,
    input logic [SW-1:0]         commit_slot,
    input logic                  fifo_push,
    input logic [SLOTS-1:0]      cfg_rx_mask,
    input logic                  rd_valid,
    input logic                  rd_ready,
    input logic [CW-1:0]         fifo_count,
    input logic                  fifo_ovr,
    input logic                  irq,
    input logic [SLOTS*WMAX-1:0] slot_data,
    input logic [SLOTS-1:0]      slot_ovr
);
    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));

    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ovr |=> fifo_ovr);

    p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push && fifo_count == CW'(DEPTH) && !rd_ready |=> fifo_ovr && fifo_count == CW'(DEPTH));

    p_push_grows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push && fifo_count < CW'(DEPTH) && !rd_ready |=> fifo_count == $past(fifo_count) + 1'b1);

    p_valid_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == (fifo_count != '0));

    p_slot_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((slot_ovr & $past(slot_ovr)) == $past(slot_ovr)));

    p_masked_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit && !cfg_rx_mask[commit_slot] |=> $stable(slot_data) && !$rose(fifo_ovr));

    p_irq_nonempty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> fifo_count != '0);
endmodule

bind tdm_slot_rx tdm_slot_rx_chk #(.SLOTS(SLOTS), .WMAX(WMAX), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_slot(commit_slot),
    .fifo_push(fifo_push), .cfg_rx_mask(cfg_rx_mask), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .fifo_count(fifo_count), .fifo_ovr(fifo_ovr), .irq(irq),
    .slot_data(slot_data), .slot_ovr(slot_ovr)
);

// File: tb/test_tdm_slot_rx.sv
module test_tdm_slot_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0, fsync = 1'b0, sdata = 1'b0;
    logic        cfg_word16 = 1'b1;
    logic [1:0]  cfg_nslots = 2'd3;
    logic [3:0]  cfg_rx_mask = 4'hF, cfg_route_reg = 4'h0, cfg_warn_lim = 4'd7;
    logic        rd_valid, rd_ready = 1'b0;
    logic [15:0] rd_data;
    logic [3:0]  fifo_count;
    logic        fifo_ovr, irq;
    logic [63:0] slot_data;
    logic [3:0]  slot_valid, slot_ovr;
    logic [3:0]  slot_rd = 4'h0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    tdm_slot_rx i_tdm_slot_rx (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .sdata(sdata),
        .cfg_word16(cfg_word16), .cfg_nslots(cfg_nslots), .cfg_rx_mask(cfg_rx_mask),
        .cfg_route_reg(cfg_route_reg), .cfg_warn_lim(cfg_warn_lim),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .fifo_count(fifo_count), .fifo_ovr(fifo_ovr), .irq(irq),
        .slot_data(slot_data), .slot_valid(slot_valid), .slot_rd(slot_rd),
        .slot_ovr(slot_ovr)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rd_ready = 1'b0; slot_rd = 4'h0; bclk = 1'b0; fsync = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic drive_bit(input logic sd, input logic fs);
        @(negedge clk);
        bclk = 1'b1; sdata = sd; fsync = fs;
        repeat (4) @(negedge clk);
        bclk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // words[16k+15:16k] is slot k; 8-bit mode uses its low byte
    task automatic send_frame(input logic [63:0] words, input int ns, input bit w16,
                              input bit long_fs, input int gap);
        int w = w16 ? 16 : 8;
        for (int s = 0; s < ns; s++)
            for (int b = w - 1; b >= 0; b--)
                drive_bit(words[16*s + b], long_fs ? (s == 0) : (s == 0 && b == w - 1));
        for (int g = 0; g < gap; g++) drive_bit($urandom_range(1, 0) == 1, 1'b0);
        repeat (4) @(negedge clk);
    endtask

    task automatic pop_check(input logic [15:0] exp, input string tag);
        check(rd_valid === 1'b1, tag, {63'd0, rd_valid}, 64'd1);
        check(rd_data === exp, tag, {48'd0, rd_data}, {48'd0, exp});
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check(fifo_count === 4'd0 && rd_valid === 1'b0 && irq === 1'b0, "R1 fifo idle",
              {fifo_count, rd_valid, irq}, 0);
        check(slot_valid === 4'h0 && slot_ovr === 4'h0 && fifo_ovr === 1'b0, "R1 flags clear",
              {slot_valid, slot_ovr, fifo_ovr}, 0);
    endtask

    task automatic t_fifo16();
        do_reset();
        cfg_word16 = 1'b1; cfg_nslots = 2'd3; cfg_rx_mask = 4'hF; cfg_route_reg = 4'h0;
        cfg_warn_lim = 4'd3;
        send_frame(64'h0718_E5F6_C3D4_A1B2, 4, 1'b1, 1'b0, 3);
        check(fifo_count === 4'd4, "R2 R6 four words queued", fifo_count, 4);
        check(irq === 1'b1, "R10 irq above limit", irq, 1);
        pop_check(16'hA1B2, "R3 R6 slot0 word");
        check(irq === 1'b0, "R10 irq at limit", irq, 0);
        pop_check(16'hC3D4, "R3 R6 slot1 word");
        pop_check(16'hE5F6, "R3 R6 slot2 word");
        pop_check(16'h0718, "R3 R6 slot3 word");
        check(rd_valid === 1'b0, "R6 empty after drain", rd_valid, 0);
    endtask

    task automatic t_mask();
        do_reset();
        cfg_word16 = 1'b1; cfg_nslots = 2'd3; cfg_rx_mask = 4'b0101; cfg_route_reg = 4'h0;
        cfg_warn_lim = 4'd7;
        send_frame(64'h4444_3333_2222_1111, 4, 1'b1, 1'b1, 2);
        check(fifo_count === 4'd2, "R5 only assigned slots kept", fifo_count, 2);
        check(slot_valid === 4'h0, "R5 no register written", slot_valid, 0);
        pop_check(16'h1111, "R5 R2 long sync slot0");
        pop_check(16'h3333, "R5 slot2");
    endtask

    task automatic t_8bit();
        do_reset();
        cfg_word16 = 1'b0; cfg_nslots = 2'd1; cfg_rx_mask = 4'hF; cfg_route_reg = 4'h0;
        send_frame(64'h0000_0000_77C3_995A, 2, 1'b0, 1'b0, 16);
        check(fifo_count === 4'd2, "R2 bits after last slot ignored", fifo_count, 2);
        pop_check(16'h005A, "R4 slot0 zero extended");
        pop_check(16'h00C3, "R4 slot1 zero extended");
    endtask

    task automatic t_regs();
        do_reset();
        cfg_word16 = 1'b1; cfg_nslots = 2'd3; cfg_rx_mask = 4'hF; cfg_route_reg = 4'hF;
        send_frame(64'hDDDD_CCCC_BBBB_AAAA, 4, 1'b1, 1'b0, 2);
        check(slot_valid === 4'hF, "R7 all slot regs valid", slot_valid, 4'hF);
        check(slot_data === 64'hDDDD_CCCC_BBBB_AAAA, "R7 slot reg data", slot_data, 64'hDDDD_CCCC_BBBB_AAAA);
        check(fifo_count === 4'd0, "R7 fifo untouched", fifo_count, 0);
        @(negedge clk); slot_rd = 4'b0010; @(negedge clk); slot_rd = 4'h0;
        check(slot_valid === 4'b1101, "R7 read clears valid", slot_valid, 4'b1101);
        send_frame(64'h4321_8765_0FED_1234, 4, 1'b1, 1'b0, 2);
        check(slot_ovr === 4'b1101, "R8 overrun on unread slots", slot_ovr, 4'b1101);
        check(slot_data === 64'h4321_8765_0FED_1234, "R8 new word replaces", slot_data, 64'h4321_8765_0FED_1234);
        @(negedge clk); slot_rd = 4'hF; @(negedge clk); slot_rd = 4'h0;
        check(slot_ovr === 4'b1101 && slot_valid === 4'h0, "R8 overrun sticky", {slot_ovr, slot_valid}, 8'hD0);
    endtask

    task automatic t_fifo_ovr();
        do_reset();
        cfg_word16 = 1'b1; cfg_nslots = 2'd3; cfg_rx_mask = 4'hF; cfg_route_reg = 4'h0;
        cfg_warn_lim = 4'd7;
        for (int f = 0; f < 3; f++) begin
            logic [63:0] w;
            for (int s = 0; s < 4; s++) w[16*s +: 16] = 16'h1000 + 16'(f * 4 + s);
            send_frame(w, 4, 1'b1, 1'b0, 1);
        end
        check(fifo_count === 4'd8, "R9 fifo holds eight", fifo_count, 8);
        check(fifo_ovr === 1'b1, "R9 overrun flagged", fifo_ovr, 1);
        check(irq === 1'b1, "R10 irq when full", irq, 1);
        for (int i = 0; i < 8; i++) pop_check(16'h1000 + 16'(i), "R9 first eight kept");
        check(fifo_ovr === 1'b1 && rd_valid === 1'b0, "R9 sticky after drain", {fifo_ovr, rd_valid}, 2'b10);
    endtask

    initial begin
        t_reset();
        t_fifo16();
        t_mask();
        t_8bit();
        t_regs();
        t_fifo_ovr();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule